// File: doc/BRIEF.md
# Comma-Detect Word Aligner

This block turns a retimed serial bit stream into 10-bit parallel characters and finds the character boundary without help from outside. Every incoming bit, qualified by a bit-clock enable, enters a shift register. The newest seven bits are compared against a fixed comma pattern that appears only inside the three synchronisation special characters of the 8b/10b code. When the pattern is seen and alignment is allowed, the block moves its word boundary so that the comma becomes the start of the next output character.

Each complete character is delivered with a one-cycle valid strobe. A comma flag marks every delivered character whose first seven bits form the comma. While alignment is disabled the boundary stays where it is. A comma that straddles the boundary is then passed through as ordinary data, and one that already sits on the boundary is still flagged.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is low and in the first cycle after it, `word_o` is all zeros and `word_vld_o` and `comma_o` are low.
- R2: Bits are delivered in arrival order: the first bit of a character appears on `word_o[0]` and the tenth on `word_o[9]`. After reset, the first `word_vld_o` follows the tenth accepted bit, unless a realignment has moved the boundary.
- R3: Without realignment, one character is delivered for every ten accepted bits. `word_vld_o` is high for exactly the one clock cycle that follows the cycle in which the tenth bit was accepted.
- R4: In a cycle with `bit_en` low, `ser_in` is ignored and neither the bit count nor the history changes.
- R5: With `align_en` high, an accepted bit that completes the comma (received bits 0 to 6 equal to 0,0,1,1,1,1,1) moves the boundary. The comma's first bit becomes `word_o[0]` of the next character, which is delivered three accepted bits later. Bits of the interrupted partial character are discarded.
- R6: If the bit that completes a comma also completes a character under the old boundary, that character is still delivered before the boundary moves.
- R7: With `align_en` low, the boundary never moves, and a comma that is not on the boundary is delivered unflagged inside ordinary characters.
- R8: `comma_o` is high, together with `word_vld_o` for that single cycle, exactly when the delivered character has bits 0 to 6 equal to 0,0,1,1,1,1,1. This holds whatever the state of `align_en`.
- R9: A comma match requires seven bits accepted since reset, so reset-state history never triggers a realignment.
- R10: Between valid strobes `word_o` holds the last delivered character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `ser_in` as a new bit this cycle |
| ser_in | input | 1 | Serial data bit |
| align_en | input | 1 | Allows the boundary to move on a comma |
| word_o | output | 10 | Last delivered character, bit 0 received first |
| word_vld_o | output | 1 | One-cycle strobe for a new character |
| comma_o | output | 1 | Delivered character starts with the comma |

## Verification
Every result is due exactly one clock after the cycle in which the bit that completes a character is accepted. A realignment shows up only as a delivery three accepted bits later. The bench driver computes the due cycle when it sends that bit and stores it with the expected character and comma flag. The monitor samples on falling edges and rejects any strobe that arrives in a different cycle. Idle cycles with random `ser_in` are inserted between bits, so any advance during a disabled cycle shifts a later delivery and is caught.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
    // Default character and comma geometry.
    localparam int unsigned CWA_WORD_W  = 10;
    localparam int unsigned CWA_COMMA_W = 7;
    // Bit i holds the i-th received bit of the comma: 0,0,1,1,1,1,1.
    localparam logic [CWA_COMMA_W-1:0] CWA_COMMA_DEF = 7'b111_1100;
endpackage

// File: rtl/cwa_hist.sv
module cwa_hist #(
    parameter int unsigned WORD_W = cwa_pkg::CWA_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              ser_in,
    output logic [WORD_W-1:0] hist_nxt
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
    } hist_t;

    hist_t hist_d, hist_q;

    // Newest bit enters at the top; bit 0 is the oldest held bit.
    always_comb begin
        hist_d = hist_q;
        if (bit_en) begin
            hist_d.sh = {ser_in, hist_q.sh[WORD_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_nxt = hist_d.sh;

    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> hist_q.sh[WORD_W-1] == $past(ser_in));

    p_idle_hist_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(hist_q.sh));
endmodule

// File: rtl/cwa_match.sv
module cwa_match #(
    parameter int unsigned      N   = cwa_pkg::CWA_COMMA_W,
    parameter logic [N-1:0]     PAT = cwa_pkg::CWA_COMMA_DEF
) (
    input  logic [N-1:0] win,
    output logic         hit
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign eq[g] = ~(win[g] ^ PAT[g]);
    end

    assign hit = &eq;
endmodule

// File: rtl/cwa_bound.sv
module cwa_bound #(
    parameter int unsigned WORD_W  = cwa_pkg::CWA_WORD_W,
    parameter int unsigned COMMA_W = cwa_pkg::CWA_COMMA_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic realign,
    output logic word_done,
    output logic hist_ok
);
    localparam int unsigned CNT_W  = $clog2(WORD_W);
    localparam int unsigned FILL_W = $clog2(COMMA_W);
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0]  CNT_ALIGN = CNT_W'(COMMA_W);
    localparam logic [FILL_W-1:0] FILL_MAX  = FILL_W'(COMMA_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;   // bits of the current character already held
        logic [FILL_W-1:0] fill;  // bits seen since reset, saturating
    } bnd_t;

    bnd_t bnd_d, bnd_q;

    always_comb begin
        bnd_d = bnd_q;
        if (bit_en) begin
            if (bnd_q.fill != FILL_MAX) begin
                bnd_d.fill = bnd_q.fill + FILL_W'(1);
            end
            if (realign) begin
                bnd_d.cnt = CNT_ALIGN;
            end else if (bnd_q.cnt == CNT_LAST) begin
                bnd_d.cnt = '0;
            end else begin
                bnd_d.cnt = bnd_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bnd_q <= '0;
        end else begin
            bnd_q <= bnd_d;
        end
    end

    assign word_done = bit_en && (bnd_q.cnt == CNT_LAST);
    assign hist_ok   = (bnd_q.fill == FILL_MAX);

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_q.cnt <= CNT_LAST);

    p_idle_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(bnd_q.cnt) && $stable(bnd_q.fill));

    p_realign_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> bnd_q.cnt == CNT_ALIGN);

    p_realign_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        realign |-> bit_en && hist_ok);
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
    parameter int unsigned             WORD_W    = cwa_pkg::CWA_WORD_W,
    parameter int unsigned             COMMA_W   = cwa_pkg::CWA_COMMA_W,
    parameter logic [COMMA_W-1:0]      COMMA_PAT = cwa_pkg::CWA_COMMA_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              ser_in,
    input  logic              align_en,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              comma_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              vld;
        logic              comma;
    } out_t;

    logic [WORD_W-1:0] hist_nxt;
    logic              win_hit;
    logic              word_hit;
    logic              word_done;
    logic              hist_ok;
    logic              realign;
    out_t              out_d, out_q;

    cwa_hist #(.WORD_W(WORD_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .ser_in   (ser_in),
        .hist_nxt (hist_nxt)
    );

    // Newest COMMA_W bits, oldest of them at the low end.
    cwa_match #(.N(COMMA_W), .PAT(COMMA_PAT)) u_win_match (
        .win (hist_nxt[WORD_W-1 -: COMMA_W]),
        .hit (win_hit)
    );

    // First COMMA_W bits of the character being completed.
    cwa_match #(.N(COMMA_W), .PAT(COMMA_PAT)) u_word_match (
        .win (hist_nxt[COMMA_W-1:0]),
        .hit (word_hit)
    );

    assign realign = bit_en && align_en && hist_ok && win_hit;

    cwa_bound #(.WORD_W(WORD_W), .COMMA_W(COMMA_W)) u_bound (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .realign   (realign),
        .word_done (word_done),
        .hist_ok   (hist_ok)
    );

    always_comb begin
        out_d       = out_q;
        out_d.vld   = word_done;
        out_d.comma = word_done && word_hit;
        if (word_done) begin
            out_d.word = hist_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign word_o     = out_q.word;
    assign word_vld_o = out_q.vld;
    assign comma_o    = out_q.comma;

    p_vld_after_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> $past(bit_en));

    p_comma_with_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        comma_o |-> word_vld_o);

    p_comma_pattern_r8: assert property (@(posedge clk) disable iff (!rst_n)
        comma_o |-> word_o[COMMA_W-1:0] == COMMA_PAT);

    p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_o |-> $stable(word_o));

    p_no_realign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !align_en |-> !realign);
endmodule

// File: tb/tb_comma_word_aligner.sv
module tb_comma_word_aligner;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       ser_in = 1'b0;
    logic       align_en = 1'b0;
    logic [9:0] word_o;
    logic       word_vld_o;
    logic       comma_o;

    comma_word_aligner dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .ser_in     (ser_in),
        .align_en   (align_en),
        .word_o     (word_o),
        .word_vld_o (word_vld_o),
        .comma_o    (comma_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    // Scoreboard queues
    logic [9:0] q_word[$];
    bit         q_comma[$];
    int         q_due[$];
    string      q_tag[$];

    // Reference stream model
    bit    mb[$];
    int    mcnt = 0;
    string cur_tag = "R2";
    logic [9:0] last_w = '0;

    function automatic bit comma_ends_here();
        string cs = "0011111";
        int base = mb.size() - 7;
        for (int i = 0; i < 7; i++) begin
            if (mb[base+i] != (cs[i] == "1")) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive_bit(bit b, bit al);
        logic [9:0] w;
        bit cm;
        @(negedge clk);
        ser_in = b;
        bit_en = 1'b1;
        align_en = al;
        mb.push_back(b);
        mcnt++;
        if (mcnt == 10) begin
            for (int i = 0; i < 10; i++) w[i] = mb[mb.size()-10+i];
            cm = 1'b1;
            for (int i = 0; i < 7; i++) if (w[i] != (i >= 2)) cm = 1'b0;
            q_word.push_back(w);
            q_comma.push_back(cm);
            q_due.push_back(cyc + 1);
            q_tag.push_back(cur_tag);
            mcnt = 0;
        end
        if (al && mb.size() >= 7 && comma_ends_here()) mcnt = 7;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1'b0;
            ser_in = 1'($urandom_range(0, 1));
        end
    endtask

    task automatic send(string s, bit al, int gap);
        for (int i = 0; i < s.len(); i++) begin
            drive_bit(s[i] == "1", al);
            if (gap > 0) idle(gap);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (word_vld_o) begin
                if (q_word.size() == 0) begin
                    check(1'b0, "R3", "unexpected strobe", int'(word_o), 0);
                end else begin
                    automatic logic [9:0] ew = q_word.pop_front();
                    automatic bit ec = q_comma.pop_front();
                    automatic int ed = q_due.pop_front();
                    automatic string tg = q_tag.pop_front();
                    check(cyc == ed, "R3", "strobe cycle", cyc, ed);
                    check(word_o == ew, tg, "word", int'(word_o), int'(ew));
                    check(comma_o == ec, "R8", "comma flag", int'(comma_o), int'(ec));
                end
                last_w = word_o;
            end else begin
                check(word_o == last_w, "R10", "held word", int'(word_o), int'(last_w));
                check(comma_o == 1'b0, "R8", "comma without strobe", int'(comma_o), 0);
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(word_o == '0 && !word_vld_o && !comma_o, "R1", "in reset",
              int'({word_o, word_vld_o, comma_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(word_o == '0 && !word_vld_o && !comma_o, "R1", "after reset",
              int'({word_o, word_vld_o, comma_o}), 0);
        mon_on = 1'b1;

        // R9 / R2: ones after reset zeros must not match; first word after 10 bits
        cur_tag = "R9";
        send("1111100000", 1'b1, 0);

        // R3 / R4: plain words, idle gaps with random ser_in
        cur_tag = "R4";
        send("1010110010", 1'b1, 2);
        cur_tag = "R3";
        send("0110100111", 1'b1, 0);

        // R5: comma two bits into a character, partial bits dropped
        cur_tag = "R5";
        send("10", 1'b1, 0);
        send("0011111010", 1'b1, 1);
        send("1100010110", 1'b1, 0);

        // R6: comma completes on the tenth bit of a character
        cur_tag = "R6";
        send("101", 1'b1, 0);
        send("0011111010", 1'b1, 0);
        send("0101010101", 1'b1, 0);

        // R7: alignment off, misaligned comma passes unflagged
        cur_tag = "R7";
        send("1", 1'b0, 0);
        send("0011111010", 1'b0, 0);
        send("100101001", 1'b0, 0);
        // R8: aligned comma still flagged with alignment off
        cur_tag = "R8";
        send("0011111010", 1'b0, 0);
        send("0011111010110000010100111110101100000101", 1'b1, 0);

        // Mixed random stream with toggling alignment enable
        cur_tag = "R5";
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 50; i++) begin
                drive_bit(1'($urandom_range(0, 1)), k[0]);
                if ($urandom_range(0, 3) == 0) idle(1);
            end
            send("0011111010", 1'b1, 0);
        end

        idle(6);
        check(q_word.size() == 0, "R3", "undelivered words", q_word.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule